// File: doc/BRIEF.md
# Flash Erase-Block Lock Protection Unit

This unit keeps the write-protection state of every erase block in a flash memory model. A command decoder feeds it a stream of command bytes with a word address. A two-cycle sequence can lock a block, unlock it, or lock it down. A locked-down block stays locked until the next reset. Changes apply to one block at a time and show up at the outputs on the very next cycle.

Two lookups run in parallel on the current state. A query port returns the 2-bit protection status of any address. An access port tells the array controller whether a program or an erase to an address may go ahead.

A refused access raises sticky error flags. A clear-status command in the same command stream clears them. The array is built from main-size address slots, and one slot is split into smaller parameter blocks. A parameter selects whether that split slot is the highest slot or the lowest one.

The command stream uses a valid strobe with no ready signal. The unit never applies back-pressure, so every cycle with `cmd_valid` high consumes exactly one command byte.

Top module: `flash_lock_unit`

## Requirements
- R1: After reset every block reads status 2'b01 (bit 0 = locked, bit 1 = locked-down) and `err_flags` is 3'b000.
- R2: A setup byte 0x60 followed by a confirm byte acts on the block addressed in the confirm cycle. The confirm byte 0x01 locks the block, 0xD0 unlocks it and 0x2F locks it down. Only the confirm-cycle address matters.
- R3: Any confirm byte other than 0x01, 0xD0 or 0x2F ends the pending setup with no change. A lock, unlock or lock-down byte that does not follow a setup byte is ignored.
- R4: Lock-down sets both status bits. A later unlock of that block is ignored, and only reset clears lock-down.
- R5: A change made in a confirm cycle is visible on `qry_status` and `acc_allow` in the next cycle. An access in the confirm cycle itself sees the old state. No other block changes.
- R6: `qry_status` gives the status of the block holding `qry_addr` in the same cycle: bit 0 = locked, bit 1 = locked-down.
- R7: `acc_allow` is high exactly when `acc_valid` is high and the addressed block is not locked.
- R8: A refused access sets `err_flags` in the next cycle. Bit 0 means block locked, bit 1 means program error (`acc_erase`=0) and bit 2 means erase error (`acc_erase`=1). The flags are sticky.
- R9: Byte 0x50 sent outside a setup clears `err_flags`. If a refusal happens in the same cycle, the refusal's bits are still set.
- R10: The address is {slot, sub, offset}, with the offset taking PARAM_AW bits. With TOP_PARAM=1 the highest slot holds the PSPLIT parameter blocks; with TOP_PARAM=0 the lowest slot holds them. Every other slot is one main block, so all addresses in a block share one state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| cmd_addr | input | ADDR_W | Word address of the command |
| acc_valid | input | 1 | Program or erase request present |
| acc_erase | input | 1 | 1 = erase, 0 = program |
| acc_addr | input | ADDR_W | Word address of the request |
| acc_allow | output | 1 | Request may proceed |
| qry_addr | input | ADDR_W | Word address to query |
| qry_status | output | 2 | {locked-down, locked} of the queried block |
| err_flags | output | 3 | {erase err, program err, block locked} |

## Verification
`qry_status` and `acc_allow` are combinational, so they are due in the same cycle as their inputs. A confirm byte changes them one cycle later. A refused access shows on `err_flags` one cycle after the refusal.

The bench drives inputs at the falling edge and samples all outputs 1 ns later, before the next rising edge. It advances its reference model only at the rising edge. This way every comparison sees exactly the state the registers hold in that cycle.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h01;
  localparam logic [7:0] CMD_UNLOCK = 8'hD0;
  localparam logic [7:0] CMD_DOWN   = 8'h2F;
  localparam logic [7:0] CMD_CLRSR  = 8'h50;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_DOWN   = 2'd3
  } lk_op_e;
endpackage

// File: rtl/flk_decode.sv
module flk_decode #(
  parameter int SLOTS     = 8,
  parameter int MAIN_AW   = 16,
  parameter int PARAM_AW  = 14,
  parameter bit TOP_PARAM = 1'b1,
  parameter int ADDR_W    = 19,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int SUB_W  = MAIN_AW - PARAM_AW;
  localparam int PSPLIT = 1 << SUB_W;
  localparam int SLOT_W = ADDR_W - MAIN_AW;

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;

  assign slot = addr[ADDR_W-1:MAIN_AW];
  assign sub  = addr[MAIN_AW-1:PARAM_AW];

  generate
    if (TOP_PARAM) begin : g_top
      always_comb begin
        if (slot == SLOT_W'(SLOTS - 1)) idx = IDX_W'(SLOTS - 1) + IDX_W'(sub);
        else                            idx = IDX_W'(slot);
      end
    end else begin : g_bot
      always_comb begin
        if (slot == '0) idx = IDX_W'(sub);
        else            idx = IDX_W'(slot) + IDX_W'(PSPLIT - 1);
      end
    end
  endgenerate
endmodule

// File: rtl/flk_cmd_fsm.sv
module flk_cmd_fsm
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output lk_op_e     op,
  output logic       clr_req
);
  logic pend_q;

  always_comb begin
    op = OP_NONE;
    if (cmd_valid && pend_q) begin
      unique case (cmd_code)
        CMD_LOCK:   op = OP_LOCK;
        CMD_UNLOCK: op = OP_UNLOCK;
        CMD_DOWN:   op = OP_DOWN;
        default:    op = OP_NONE;
      endcase
    end
  end

  assign clr_req = cmd_valid && !pend_q && (cmd_code == CMD_CLRSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (cmd_valid) pend_q <= !pend_q && (cmd_code == CMD_SETUP);
  end

  AST_SETUP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cmd_valid) |=> !pend_q) else $error("setup outlived confirm"); // R3
  AST_OP_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE) |-> (pend_q && cmd_valid)) else $error("op without setup"); // R3
endmodule

// File: rtl/flk_lock_array.sv
module flk_lock_array
  import flk_pkg::*;
#(
  parameter int NBLK  = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lk_op_e           op,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [IDX_W-1:0] a_idx,
  output logic [1:0]       q_stat,
  output logic             a_lock
);
  logic [NBLK-1:0] lk_q;
  logic [NBLK-1:0] dn_q;

  generate
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
      logic hit;
      assign hit = (op_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lk_q[i] <= 1'b1;
          dn_q[i] <= 1'b0;
        end else if (hit) begin
          unique case (op)
            OP_LOCK:   lk_q[i] <= 1'b1;
            OP_UNLOCK: if (!dn_q[i]) lk_q[i] <= 1'b0;
            OP_DOWN:   begin lk_q[i] <= 1'b1; dn_q[i] <= 1'b1; end
            default:   ;
          endcase
        end
      end

      AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q[i] |=> dn_q[i]) else $error("lock-down lost"); // R4
      AST_DOWN_IMPLIES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q[i] |-> lk_q[i]) else $error("locked-down block open"); // R4
      AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_q[i]) |-> $past(op == OP_UNLOCK && op_idx == IDX_W'(i)))
        else $error("unlock without command"); // R2
    end
  endgenerate

  always_comb begin
    q_stat = 2'b00;
    a_lock = 1'b0;
    if (int'(q_idx) < NBLK) q_stat = {dn_q[q_idx], lk_q[q_idx]};
    if (int'(a_idx) < NBLK) a_lock = lk_q[a_idx];
  end
endmodule

// File: rtl/flk_status.sv
module flk_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       deny,
  input  logic       deny_erase,
  input  logic       clr_req,
  output logic [2:0] err
);
  logic [2:0] err_q;
  logic [2:0] set_v;

  assign set_v = deny ? {deny_erase, !deny_erase, 1'b1} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 3'b000;
    else        err_q <= (clr_req ? 3'b000 : err_q) | set_v;
  end

  assign err = err_q;

  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> (err_q[0] && (err_q[1] != err_q[2] || $past(clr_req) == 1'b0)))
    else $error("refusal not flagged"); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && err_q[0]) |=> err_q[0]) else $error("flag dropped"); // R8
endmodule

// File: rtl/flash_lock_unit.sv
module flash_lock_unit
  import flk_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int MAIN_AW   = 16,
  parameter int PARAM_AW  = 14,
  parameter bit TOP_PARAM = 1'b1,
  localparam int SUB_W    = MAIN_AW - PARAM_AW,
  localparam int PSPLIT   = 1 << SUB_W,
  localparam int NBLK     = SLOTS - 1 + PSPLIT,
  localparam int IDX_W    = $clog2(NBLK),
  localparam int ADDR_W   = MAIN_AW + $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              acc_valid,
  input  logic              acc_erase,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_allow,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic [1:0]        qry_status,
  output logic [2:0]        err_flags
);
  logic [IDX_W-1:0] cmd_idx, acc_idx, qry_idx;
  lk_op_e           op;
  logic             clr_req;
  logic             a_lock;
  logic             deny;

  flk_decode #(.SLOTS(SLOTS), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW),
               .TOP_PARAM(TOP_PARAM), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_dec_cmd (.addr(cmd_addr), .idx(cmd_idx));
  flk_decode #(.SLOTS(SLOTS), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW),
               .TOP_PARAM(TOP_PARAM), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_dec_acc (.addr(acc_addr), .idx(acc_idx));
  flk_decode #(.SLOTS(SLOTS), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW),
               .TOP_PARAM(TOP_PARAM), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
    u_dec_qry (.addr(qry_addr), .idx(qry_idx));

  flk_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .op(op), .clr_req(clr_req)
  );

  flk_lock_array #(.NBLK(NBLK), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .op(op), .op_idx(cmd_idx),
    .q_idx(qry_idx), .a_idx(acc_idx), .q_stat(qry_status), .a_lock(a_lock)
  );

  assign deny      = acc_valid && a_lock;
  assign acc_allow = acc_valid && !a_lock;

  flk_status u_sts (
    .clk(clk), .rst_n(rst_n), .deny(deny), .deny_erase(acc_erase),
    .clr_req(clr_req), .err(err_flags)
  );

  AST_LOCKED_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == qry_addr && qry_status[0]) |-> !acc_allow)
    else $error("locked block allowed"); // R7
  AST_IDLE_NO_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_allow) else $error("allow without request"); // R7
endmodule

// File: tb/tb_flash_lock_unit.sv
`timescale 1ns/1ps
module tb_flash_lock_unit;
  localparam int AW = 19;
  localparam int NB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic acc_valid = 1'b0;
  logic acc_erase = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [AW-1:0] qry_addr = '0;
  logic allow_t, allow_b;
  logic [1:0] qs_t, qs_b;
  logic [2:0] er_t, er_b;

  always #5 clk = ~clk;

  flash_lock_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .acc_valid(acc_valid), .acc_erase(acc_erase),
    .acc_addr(acc_addr), .acc_allow(allow_t), .qry_addr(qry_addr),
    .qry_status(qs_t), .err_flags(er_t));

  flash_lock_unit #(.TOP_PARAM(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .acc_valid(acc_valid), .acc_erase(acc_erase),
    .acc_addr(acc_addr), .acc_allow(allow_b), .qry_addr(qry_addr),
    .qry_status(qs_b), .err_flags(er_b));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  bit lk [2][NB];
  bit dn [2][NB];
  bit [2:0] er [2];
  bit pend;

  function automatic int bidx(int a, int top);
    int s = a >> 16;
    int u = (a >> 14) & 3;
    if (top != 0) return (s == 7) ? 7 + u : s;
    return (s == 0) ? u : s + 3;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < NB; i++) begin lk[t][i] = 1; dn[t][i] = 0; end
      er[t] = 3'b000;
    end
    pend = 0;
  endtask

  task automatic model_step();
    if (!rst_n) begin model_reset(); return; end
    for (int t = 0; t < 2; t++) begin
      bit [2:0] ne;
      int top = (t == 0) ? 1 : 0;
      ne = (cmd_valid && !pend && cmd_code == 8'h50) ? 3'b000 : er[t];
      if (acc_valid && lk[t][bidx(acc_addr, top)]) ne |= acc_erase ? 3'b101 : 3'b011;
      er[t] = ne;
      if (cmd_valid && pend) begin
        int b = bidx(cmd_addr, top);
        case (cmd_code)
          8'h01: lk[t][b] = 1;
          8'hD0: if (!dn[t][b]) lk[t][b] = 0;
          8'h2F: begin lk[t][b] = 1; dn[t][b] = 1; end
          default: ;
        endcase
      end
    end
    if (cmd_valid) pend = !pend && cmd_code == 8'h60;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    for (int t = 0; t < 2; t++) begin
      int top = (t == 0) ? 1 : 0;
      int qi = bidx(qry_addr, top);
      int ai = bidx(acc_addr, top);
      int eq = {dn[t][qi], lk[t][qi]};
      int ea = (acc_valid && !lk[t][ai]) ? 1 : 0;
      chk(tag, t == 0 ? "top qry_status(R6)" : "bot qry_status(R6)", t == 0 ? qs_t : qs_b, eq);
      chk(tag, t == 0 ? "top acc_allow(R7)" : "bot acc_allow(R7)", t == 0 ? allow_t : allow_b, ea);
      chk(tag, t == 0 ? "top err_flags(R8)" : "bot err_flags(R8)", t == 0 ? er_t : er_b, er[t]);
    end
  endtask

  task automatic cyc(string tag);
    #1;
    if (rst_n) compare(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
  endtask

  task automatic cmd(logic [7:0] c, int a, string tag);
    cmd_valid = 1; cmd_code = c; cmd_addr = AW'(a);
    cyc(tag);
    cmd_valid = 0;
  endtask

  task automatic acc(bit e, int a, string tag);
    acc_valid = 1; acc_erase = e; acc_addr = AW'(a);
    cyc(tag);
    acc_valid = 0;
  endtask

  task automatic look(int a, string tag);
    qry_addr = AW'(a);
    cyc(tag);
  endtask

  initial begin
    model_reset();
    @(negedge clk); cycles++;
    @(negedge clk); cycles++;
    rst_n = 1;
    // R1 reset state across both layouts
    look(32'h0_0000, "R1"); look(32'h7_C000, "R1"); look(32'h3_1234, "R1");
    // R2 unlock main block in slot 2, R10 aliasing inside it
    cmd(8'h60, 32'h2_0005, "R2"); cmd(8'hD0, 32'h2_0005, "R2");
    look(32'h2_FFFF, "R10"); look(32'h3_0000, "R5");
    // R7 / R8 access checks
    acc(0, 32'h2_1000, "R7"); acc(0, 32'h3_1000, "R8"); look(32'h3_0000, "R8");
    acc(1, 32'h3_1000, "R8"); look(32'h3_0000, "R8");
    // R9 clear, then clear with refusal in the same cycle
    cmd(8'h50, 0, "R9"); look(0, "R9");
    acc_valid = 1; acc_erase = 1; acc_addr = AW'(32'h5_0000);
    cmd(8'h50, 0, "R9"); acc_valid = 0; look(0, "R9");
    cmd(8'h50, 0, "R9");
    // R3 stray confirm, abandoned setup
    cmd(8'hD0, 32'h4_0000, "R3"); look(32'h4_0000, "R3");
    cmd(8'h60, 32'h4_0000, "R3"); cmd(8'hFF, 32'h4_0000, "R3");
    cmd(8'hD0, 32'h4_0000, "R3"); look(32'h4_0000, "R3");
    // R4 lock-down on a top parameter block, unlock ignored
    cmd(8'h60, 32'h7_4000, "R4"); cmd(8'h2F, 32'h7_4000, "R4");
    look(32'h7_4000, "R4");
    cmd(8'h60, 32'h7_4000, "R4"); cmd(8'hD0, 32'h7_4000, "R4");
    look(32'h7_4000, "R4");
    // R10 neighbouring parameter blocks are separate
    cmd(8'h60, 32'h7_8000, "R10"); cmd(8'hD0, 32'h7_8000, "R10");
    look(32'h7_8000, "R10"); look(32'h7_C000, "R10"); look(32'h7_0000, "R10");
    look(32'h0_4000, "R10"); look(32'h0_8000, "R10");
    // R2 relock
    cmd(8'h60, 32'h2_0000, "R2"); cmd(8'h01, 32'h2_0000, "R2"); look(32'h2_0000, "R2");
    // R5 access in the confirm cycle sees old state
    cmd(8'h60, 32'h4_0000, "R5");
    acc_valid = 1; acc_erase = 0; acc_addr = AW'(32'h4_0000); qry_addr = AW'(32'h4_0000);
    cmd(8'hD0, 32'h4_0000, "R5");
    cyc("R5"); acc_valid = 0;
    cmd(8'h50, 0, "R9");
    // R5 random traffic compared every cycle
    for (int n = 0; n < 400; n++) begin
      logic [7:0] codes [6] = '{8'h60, 8'h01, 8'hD0, 8'h2F, 8'h50, 8'hFF};
      cmd_valid = ($urandom % 3) != 0;
      cmd_code = codes[$urandom % 6];
      cmd_addr = AW'($urandom);
      acc_valid = $urandom % 2; acc_erase = $urandom % 2; acc_addr = AW'($urandom);
      qry_addr = AW'($urandom);
      cyc("R5");
    end
    cmd_valid = 0; acc_valid = 0;
    // R4 reset clears lock-down
    cmd(8'h60, 32'h1_0000, "R4"); cmd(8'h2F, 32'h1_0000, "R4");
    rst_n = 0; cyc("R4"); rst_n = 1;
    look(32'h1_0000, "R4"); look(32'h7_4000, "R1");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule